// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block links a processor-side port A with two memory-side ports, 1B and 2B, which typically serve an even and an odd bank in an interleaved memory. Every port is `W` bits wide (12 by default). Four data registers sit on one clock. Two of them carry data outward from A, one towards each B port. The other two carry data back from each B port towards A.

Each of the four registers has its own active-low load enable. The return path chooses one of the two inward registers through a registered path select. The output enable for port A and the shared output enable for both B ports are also registered. Every change of direction or route therefore takes effect at a rising clock edge, never directly from an input.

Each bidirectional pad appears as three signals: an input bus, an output bus and a 1-bit drive flag. The surrounding logic resolves the tri-state behaviour from these. Whenever a drive flag is low, its output bus is held at all zeros.

Top module: `tri_port_xchg`

## Requirements
- R1: When `ld_a_to_b1_n` is low at a rising edge, the outward register for port 1B captures `a_in`. Otherwise it holds its value. The register's value appears on `b1_out` whenever `b1_oe` is 1.
- R2: When `ld_a_to_b2_n` is low at a rising edge, the outward register for port 2B captures `a_in`. Otherwise it holds its value. The register's value appears on `b2_out` whenever `b2_oe` is 1. This register works independently of R1, so both outward registers may load at the same edge.
- R3: The inward register from 1B captures `b1_in` at a rising edge when `ld_b1_to_a_n` is low. The inward register from 2B captures `b2_in` at a rising edge when `ld_b2_to_a_n` is low. Each holds its value otherwise.
- R4: `sel_b1` is sampled at the rising edge. If it was 1, `a_out` shows the inward register from 1B after that edge. If it was 0, `a_out` shows the inward register from 2B.
- R5: If the select changes while both inward load enables are high, `a_out` shows the value already stored in the newly selected register, and neither inward register changes.
- R6: `a_oe_n` is sampled at the rising edge. After that edge, `a_oe` equals the inverse of the sampled value: 1 means port A drives, and 0 means port A is at high impedance.
- R7: `b_oe_n` is sampled at the rising edge. After that edge, `b1_oe` and `b2_oe` both equal its inverse. The two flags are always equal.
- R8: While a drive flag is 0, the matching output bus is all zeros.
- R9: While `rst_n` is low, and immediately after it goes low, all four data registers are zero, `sel` is taken as 0 (the 2B route), and all three drive flags are 0.
- R10: Between rising edges, `a_out` stays constant even when `a_in`, `b1_in`, `b2_in` or `sel_b1` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data arriving at port A |
| a_out | output | W | Data driven onto port A |
| a_oe | output | 1 | Port A drive flag |
| b1_in | input | W | Data arriving at port 1B |
| b1_out | output | W | Data driven onto port 1B |
| b1_oe | output | 1 | Port 1B drive flag |
| b2_in | input | W | Data arriving at port 2B |
| b2_out | output | W | Data driven onto port 2B |
| b2_oe | output | 1 | Port 2B drive flag |
| ld_a_to_b1_n | input | 1 | Load enable, A to 1B register, active low |
| ld_a_to_b2_n | input | 1 | Load enable, A to 2B register, active low |
| ld_b1_to_a_n | input | 1 | Load enable, 1B to A register, active low |
| ld_b2_to_a_n | input | 1 | Load enable, 2B to A register, active low |
| sel_b1 | input | 1 | Return route select: 1 picks 1B, 0 picks 2B |
| a_oe_n | input | 1 | Port A output enable, active low, registered |
| b_oe_n | input | 1 | Shared B output enable, active low, registered |

## Verification
The riskiest coincidence is an inward register loading at the same edge as the select switches onto it. Port A must then show the fresh B data, not the stale value. The random phase drives every load enable, the select and both output enables independently in every cycle, so loads, route changes and enable changes often fall on one edge. The directed phase forces this coincidence once on purpose. Each cycle the bench updates its own model of the four registers and the sampled controls, then compares all six outputs at the falling edge.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int NPATH = 4;
  localparam int P_AB1 = 0;
  localparam int P_AB2 = 1;
  localparam int P_B1A = 2;
  localparam int P_B2A = 3;

  typedef struct packed {
    logic sel_b1;
    logic a_en;
    logic b_en;
  } ctrl_t;
endpackage

// File: rtl/xchg_reg.sv
module xchg_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (!ld_n) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_b1,
  input  logic  a_oe_n,
  input  logic  b_oe_n,
  output ctrl_t ctl_q
);
  ctrl_t ctl_nx;

  always_comb begin
    ctl_nx.sel_b1 = sel_b1;
    ctl_nx.a_en   = ~a_oe_n;
    ctl_nx.b_en   = ~b_oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nx;
  end
endmodule

// File: rtl/xchg_gate.sv
module xchg_gate #(
  parameter int W = 12
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_comb q = en ? d : '0;
endmodule

// File: rtl/xchg_ret_mux.sv
module xchg_ret_mux #(
  parameter int W = 12
) (
  input  logic         pick_b1,
  input  logic [W-1:0] from_b1,
  input  logic [W-1:0] from_b2,
  output logic [W-1:0] ret
);
  always_comb ret = pick_b1 ? from_b1 : from_b2;
endmodule

// File: rtl/tri_port_xchg.sv
module tri_port_xchg
  import xchg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         ld_a_to_b1_n,
  input  logic         ld_a_to_b2_n,
  input  logic         ld_b1_to_a_n,
  input  logic         ld_b2_to_a_n,
  input  logic         sel_b1,
  input  logic         a_oe_n,
  input  logic         b_oe_n
);
  logic [W-1:0] d_arr  [NPATH];
  logic [W-1:0] q_arr  [NPATH];
  logic         ld_arr [NPATH];
  ctrl_t        ctl_q;
  logic [W-1:0] ret_w;

  always_comb begin
    d_arr[P_AB1]  = a_in;
    d_arr[P_AB2]  = a_in;
    d_arr[P_B1A]  = b1_in;
    d_arr[P_B2A]  = b2_in;
    ld_arr[P_AB1] = ld_a_to_b1_n;
    ld_arr[P_AB2] = ld_a_to_b2_n;
    ld_arr[P_B1A] = ld_b1_to_a_n;
    ld_arr[P_B2A] = ld_b2_to_a_n;
  end

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    xchg_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .ld_n (ld_arr[i]),
      .d    (d_arr[i]),
      .q    (q_arr[i])
    );
  end

  xchg_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_b1(sel_b1),
    .a_oe_n(a_oe_n),
    .b_oe_n(b_oe_n),
    .ctl_q (ctl_q)
  );

  xchg_ret_mux #(.W(W)) u_mux (
    .pick_b1(ctl_q.sel_b1),
    .from_b1(q_arr[P_B1A]),
    .from_b2(q_arr[P_B2A]),
    .ret    (ret_w)
  );

  xchg_gate #(.W(W)) u_gate_a  (.en(ctl_q.a_en), .d(ret_w),        .q(a_out));
  xchg_gate #(.W(W)) u_gate_b1 (.en(ctl_q.b_en), .d(q_arr[P_AB1]), .q(b1_out));
  xchg_gate #(.W(W)) u_gate_b2 (.en(ctl_q.b_en), .d(q_arr[P_AB2]), .q(b2_out));

  assign a_oe  = ctl_q.a_en;
  assign b1_oe = ctl_q.b_en;
  assign b2_oe = ctl_q.b_en;

  // Outward and inward register behaviour, observed at ports where possible
  p_out1_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a_to_b1_n && !b_oe_n) |=> (b1_out == $past(a_in)));
  p_out2_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a_to_b2_n && !b_oe_n) |=> (b2_out == $past(a_in)));
  p_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_b1_to_a_n && sel_b1 && !a_oe_n) |=> (a_out == $past(b1_in)));
  p_sel_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe_n && !sel_b1) |=> (a_out == q_arr[P_B2A]));
  p_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b1_to_a_n && ld_b2_to_a_n) |=> ($stable(q_arr[P_B1A]) && $stable(q_arr[P_B2A])));
  p_aoe_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |=> !a_oe);
  p_boe_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b1_oe == b2_oe);
  p_quiet_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0));
  p_quiet_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !b1_oe |-> ((b1_out == '0) && (b2_out == '0)));
endmodule

// File: tb/tri_port_xchg_test.sv
module tri_port_xchg_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;
  logic         ld_a_to_b1_n, ld_a_to_b2_n, ld_b1_to_a_n, ld_b2_to_a_n;
  logic         sel_b1, a_oe_n, b_oe_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic [W-1:0] m_ab1, m_ab2, m_b1a, m_b2a;
  logic         m_sel, m_aen, m_ben;

  always #10 clk = ~clk;

  tri_port_xchg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
    .ld_a_to_b1_n(ld_a_to_b1_n), .ld_a_to_b2_n(ld_a_to_b2_n),
    .ld_b1_to_a_n(ld_b1_to_a_n), .ld_b2_to_a_n(ld_b2_to_a_n),
    .sel_b1(sel_b1), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
  );

  function automatic logic [W-1:0] exp_a();
    if (!m_aen) return '0;
    return m_sel ? m_b1a : m_b2a;
  endfunction

  function automatic logic [W-1:0] exp_b(input logic [W-1:0] r);
    return m_ben ? r : '0;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2,
                       input logic [3:0] ldn, input logic s, input logic aoen, input logic boen);
    a_in = a; b1_in = b1; b2_in = b2;
    {ld_a_to_b1_n, ld_a_to_b2_n, ld_b1_to_a_n, ld_b2_to_a_n} = ldn;
    sel_b1 = s; a_oe_n = aoen; b_oe_n = boen;
  endtask

  task automatic check_all();
    chk("R3/R4 a_out", a_out, exp_a());
    chk("R6 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, m_aen});
    chk("R1 b1_out", b1_out, exp_b(m_ab1));
    chk("R2 b2_out", b2_out, exp_b(m_ab2));
    chk("R7 b1_oe", {{(W-1){1'b0}}, b1_oe}, {{(W-1){1'b0}}, m_ben});
    chk("R7 b2_oe", {{(W-1){1'b0}}, b2_oe}, {{(W-1){1'b0}}, m_ben});
  endtask

  task automatic step();
    @(posedge clk);
    if (!ld_a_to_b1_n) m_ab1 = a_in;
    if (!ld_a_to_b2_n) m_ab2 = a_in;
    if (!ld_b1_to_a_n) m_b1a = b1_in;
    if (!ld_b2_to_a_n) m_b2a = b2_in;
    m_sel = sel_b1; m_aen = !a_oe_n; m_ben = !b_oe_n;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold_a;
    void'($urandom(32'h5eed_0a17));
    rst_n = 1'b0;
    drive(12'h5a5, 12'h3c3, 12'h0f0, 4'b0000, 1'b1, 1'b0, 1'b0);
    m_ab1 = '0; m_ab2 = '0; m_b1a = '0; m_b2a = '0;
    m_sel = 0; m_aen = 0; m_ben = 0;
    repeat (2) @(negedge clk);
    // R9: reset state while loads and enables are requested
    check_all();
    drive('0, '0, '0, 4'b1111, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R9: registers read back zero after reset once outputs are enabled
    step();
    sel_b1 = 1'b0;
    step();

    // R1/R2: load both outward registers in one edge, then different values
    drive(12'habc, '0, '0, 4'b0011, 1'b0, 1'b0, 1'b0);
    step();
    drive(12'h123, '0, '0, 4'b0111, 1'b0, 1'b0, 1'b0);
    step();
    drive(12'h777, '0, '0, 4'b1011, 1'b0, 1'b0, 1'b0);
    step();

    // R3: B loads while B outputs disabled
    drive('0, 12'h111, 12'h222, 4'b1100, 1'b1, 1'b0, 1'b1);
    step();
    // R5: swap select without capture
    drive('0, 12'hfff, 12'heee, 4'b1111, 1'b0, 1'b0, 1'b1);
    step();
    chk("R5 stored 2B value", a_out, 12'h222);
    drive('0, 12'hfff, 12'heee, 4'b1111, 1'b1, 1'b0, 1'b1);
    step();
    chk("R5 stored 1B value", a_out, 12'h111);

    // R4: switch to 2B while it loads in the same edge
    drive('0, 12'h999, 12'h456, 4'b1110, 1'b0, 1'b0, 1'b0);
    step();
    chk("R4 fresh 2B data", a_out, 12'h456);

    // R10: inputs move mid-cycle, a_out must not follow
    hold_a = a_out;
    #3 drive(12'h001, 12'h002, 12'h003, 4'b0000, 1'b1, 1'b0, 1'b0);
    #3 chk("R10 a_out between edges", a_out, hold_a);
    step();

    // R8/R6: disable A with nonzero stored data
    drive('0, '0, '0, 4'b1111, 1'b1, 1'b1, 1'b0);
    step();
    chk("R8 a_out quiet", a_out, '0);
    drive('0, '0, '0, 4'b1111, 1'b1, 1'b1, 1'b1);
    step();
    chk("R8 b1_out quiet", b1_out, '0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      drive(W'($urandom()), W'($urandom()), W'($urandom()),
            r[3:0], r[4], r[5] & r[6], r[7] & r[8]);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule